// File: doc/BRIEF.md
# Byte-wide serial flash SPI master

This block lets a processor talk to an external serial flash over SPI, one byte at a time, through three memory-mapped registers. Software owns the chip select. It sets a one-bit enable register to pull the select line low and keeps it low across as many bytes as a flash command needs. For each byte, software loads the outgoing byte into the data register and writes anything to the transfer register. It then polls that same address until it reads a nonzero value, and reads the byte that came back from the data register.

The shifter runs SPI mode 0 only, most significant bit first. A parameter sets the number of system clock cycles in each half of the serial clock period. The block knows nothing about the flash command set. Command framing, addressing and multi-byte sequencing are left to software.

Register reads are registered: the value for a read request appears on `reg_rdata` in the cycle after the request.

Top module: `spi_byte_master`

## Requirements
- R1: After a synchronous active-high reset, `spi_cs_n` is 1 and `spi_sck` is 0. Reading address 0x81 returns 1 and reading address 0x82 returns 0.
- R2: A write to address 0x80 sets the enable bit from `reg_wdata[0]`. From the next cycle `spi_cs_n` equals the inverse of that bit, so 0x01 selects the flash and 0x00 deselects it. Reading 0x80 returns the enable bit in bit 0.
- R3: Any write to address 0x81 while idle starts a one-byte transfer. Reading 0x81 returns 0 while a transfer is running and 1 when idle.
- R4: A write to 0x81 during a running transfer is ignored. The transfer neither restarts nor lengthens, and exactly 8 SCK pulses are produced.
- R5: A write to address 0x82 keeps only `reg_wdata[7:0]` as the byte to send. Bits 31:8 have no effect on MOSI.
- R6: Bits leave MSB first in mode 0. MOSI is set up before the first rising SCK edge and changes only when SCK falls. MISO is sampled on each rising SCK edge.
- R7: After a transfer completes, reading 0x82 returns the 8 bits received on MISO, first received bit in bit 7, with bits 31:8 zero.
- R8: SCK is low whenever no transfer runs. Each SCK half period lasts `HALF_DIV` clock cycles. A read of 0x81 sampled at clock edge 16*`HALF_DIV` after the start edge still reports busy, and the read sampled one edge later reports ready.
- R9: A read of any address other than 0x80, 0x81 or 0x82, and any cycle without a read request, gives `reg_rdata` = 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_cs | input | 1 | Register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the request |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low flash select |

## Verification
Several properties are checked on every cycle. SCK stays low whenever the shifter is idle, and a rising SCK edge only occurs inside a transfer. MOSI holds steady except on a falling SCK edge or a start. A transfer only begins after a write to the trigger address, and chip select tracks the last enable write. Other behaviour only shows up over whole scenarios, so the bench covers it: the received byte value, the MSB-first ordering, dropping of upper data bits, the exact transfer length, and the count of SCK pulses when a second trigger arrives mid-transfer.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 32;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_ENABLE = 8'h80;
  localparam logic [ADDR_W-1:0] A_XFER   = 8'h81;
  localparam logic [ADDR_W-1:0] A_DATA   = 8'h82;

  typedef enum logic [1:0] {SEL_NONE, SEL_ENABLE, SEL_XFER, SEL_DATA} reg_sel_e;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (a)
      A_ENABLE: return SEL_ENABLE;
      A_XFER:   return SEL_XFER;
      A_DATA:   return SEL_DATA;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  generate
    if (HALF_DIV > 1) begin : g_count
      always_ff @(posedge clk) begin
        if (rst || !run)  cnt_q <= '0;
        else if (tick)    cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_every
      always_ff @(posedge clk) cnt_q <= '0;
    end
  endgenerate
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              half_tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  logic [BYTE_W-1:0] shreg_q;
  logic [BW-1:0]     bit_q;
  logic              samp_q;

  assign mosi = shreg_q[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      shreg_q <= '0;
      bit_q   <= '0;
      samp_q  <= 1'b0;
      rx_byte <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      sck     <= 1'b0;
      shreg_q <= tx_byte;
      bit_q   <= '0;
    end else if (busy && half_tick) begin
      if (!sck) begin
        sck    <= 1'b1;
        samp_q <= miso;
      end else begin
        sck     <= 1'b0;
        shreg_q <= {shreg_q[BYTE_W-2:0], samp_q};
        if (bit_q == LAST_BIT) begin
          busy    <= 1'b0;
          rx_byte <= {shreg_q[BYTE_W-2:0], samp_q};
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  reg_sel_e          sel;
  logic              wr_en, wr_xfer, wr_data, rd;
  logic              en_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] rx_byte;
  logic              busy;
  logic              half_tick;
  logic [REG_W-1:0]  rd_mux;

  assign sel     = decode(reg_addr);
  assign wr_en   = reg_cs && reg_we && (sel == SEL_ENABLE);
  assign wr_xfer = reg_cs && reg_we && (sel == SEL_XFER);
  assign wr_data = reg_cs && reg_we && (sel == SEL_DATA);
  assign rd      = reg_cs && !reg_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
      tx_q <= '0;
    end else begin
      if (wr_en)   en_q <= reg_wdata[0];
      if (wr_data) tx_q <= reg_wdata[BYTE_W-1:0];
    end
  end

  assign spi_cs_n = !en_q;

  spi_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .tick(half_tick)
  );

  spi_shift_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst(rst), .start(wr_xfer), .tx_byte(tx_q),
    .half_tick(half_tick), .miso(spi_miso), .busy(busy),
    .sck(spi_sck), .mosi(spi_mosi), .rx_byte(rx_byte)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_ENABLE: rd_mux[0] = en_q;
      SEL_XFER:   rd_mux[0] = !busy;
      SEL_DATA:   rd_mux[BYTE_W-1:0] = rx_byte;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     reg_rdata <= '0;
    else if (rd) reg_rdata <= rd_mux;
    else         reg_rdata <= '0;
  end
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_byte_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_cs,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic              spi_cs_n,
  input logic              busy
);
  // R8: serial clock rests low outside a transfer
  p_sck_idle_low_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !spi_sck);

  // R8: a rising serial clock edge only happens while busy
  p_sck_rise_busy_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_sck) |-> busy);

  // R6: MOSI moves only on a falling SCK edge inside a running transfer
  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$fell(spi_sck)) |-> $stable(spi_mosi));

  // R3: a transfer begins only after a trigger write
  p_start_after_trigger_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_cs && reg_we && reg_addr == A_XFER));

  // R2: select line follows the enable write
  p_cs_follows_enable_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_cs && reg_we && reg_addr == A_ENABLE) |=> (spi_cs_n == !$past(reg_wdata[0])));
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk(clk), .rst(rst), .reg_cs(reg_cs), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .busy(busy)
);

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int XFER_CYC   = 16 * HALF_DIV;
  localparam int NVEC       = 5;
  // {word written to data register, byte the flash returns}
  localparam logic [39:0] VEC [NVEC] = '{
    {32'h0000_00A5, 8'h3C},
    {32'hFFFF_FF00, 8'hFF},
    {32'h1234_5681, 8'h00},
    {32'hDEAD_BE7E, 8'h81},
    {32'h0000_0001, 8'h96}
  };

  logic        clk = 0, rst = 1;
  logic        reg_cs = 0, reg_we = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n;

  int checks = 0, fails = 0;
  logic [7:0] slave_byte = 8'h00;
  int fall_cnt = 0, rise_cnt = 0;
  logic [7:0] mosi_cap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master #(.HALF_DIV(HALF_DIV)) u0 (
    .clk(clk), .rst(rst), .reg_cs(reg_cs), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n)
  );

  // flash model: shifts out slave_byte MSB first, advancing on falling SCK
  assign spi_miso = slave_byte[7 - (fall_cnt % 8)];
  always @(negedge spi_sck) fall_cnt <= fall_cnt + 1;
  always @(posedge spi_sck) begin
    rise_cnt <= rise_cnt + 1;
    mosi_cap <= {mosi_cap[6:0], spi_mosi};
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // both tasks are entered at a falling clock edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_cs = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_cs = 0;
    d = reg_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    s = 0;
    for (int i = 0; i < 4 * XFER_CYC && s == 0; i++) rd(8'h81, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    check("R1 cs_n", {31'b0, spi_cs_n}, 32'd1);
    check("R1 sck", {31'b0, spi_sck}, 32'd0);
    rd(8'h81, v); check("R1 ready", v, 32'd1);
    rd(8'h82, v); check("R1 data", v, 32'd0);

    // R2 chip select control
    wr(8'h80, 32'h1);
    check("R2 cs low", {31'b0, spi_cs_n}, 32'd0);
    rd(8'h80, v); check("R2 enable readback", v, 32'd1);

    // R5 R6 R7 R8 vector table
    for (int k = 0; k < NVEC; k++) begin
      slave_byte = VEC[k][7:0];
      r0 = rise_cnt;
      wr(8'h82, VEC[k][39:8]);
      wr(8'h81, 32'h0);
      wait_ready();
      rd(8'h82, v);
      check("R7 rx byte", v, {24'b0, VEC[k][7:0]});
      check("R5 R6 mosi byte", {24'b0, mosi_cap}, {24'b0, VEC[k][15:8]});
      check("R8 pulses", rise_cnt - r0, 32'd8);
      check("R8 sck idle", {31'b0, spi_sck}, 32'd0);
    end

    // R3 R8 exact busy window
    slave_byte = 8'h5A;
    wr(8'h82, 32'hC3);
    wr(8'h81, 32'h7);
    rd(8'h81, v); check("R3 busy after start", v, 32'd0);
    repeat (XFER_CYC - 2) @(negedge clk);
    rd(8'h81, v); check("R8 busy at last edge", v, 32'd0);
    rd(8'h81, v); check("R8 ready one edge later", v, 32'd1);

    // R4 trigger while busy is ignored
    slave_byte = 8'hE1;
    r0 = rise_cnt;
    wr(8'h82, 32'h3D);
    wr(8'h81, 32'h0);
    repeat (5) @(negedge clk);
    wr(8'h81, 32'h0);
    repeat (XFER_CYC - 7) @(negedge clk);
    rd(8'h81, v); check("R4 no restart busy", v, 32'd0);
    rd(8'h81, v); check("R4 no restart ready", v, 32'd1);
    check("R4 pulse count", rise_cnt - r0, 32'd8);
    rd(8'h82, v); check("R4 rx", v, 32'hE1);

    // R9 unmapped address and idle cycle
    rd(8'h83, v); check("R9 unmapped", v, 32'd0);
    @(negedge clk);
    check("R9 no request", reg_rdata, 32'd0);

    // R2 deselect
    wr(8'h80, 32'h0);
    check("R2 cs high", {31'b0, spi_cs_n}, 32'd1);
    rd(8'h80, v); check("R2 enable cleared", v, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule